// File: doc/BRIEF.md
# Threshold-Driven Frame Receive FIFO

This block buffers received serial-link frame bytes between the bit-level receiver and whoever empties it, either a processor doing programmed reads or a DMA engine. Each stored entry is a data byte plus a one-bit tag. When a frame closes, the receiver pushes a status byte with the tag set, so the storage holds frame boundaries in line with the data.

On the read side three indications are produced. A DMA request comes on once the fill level has reached a programmable threshold. A data-ready flag uses the same threshold, and it also comes on for the bytes of a closed frame even when the threshold is not met. An end-of-frame flag shows that a status entry has reached the head. That status entry can only be removed by an explicit acknowledge, so the next frame's bytes cannot be read before software has taken note of the previous frame's status. Two interrupt outputs follow the data-ready and end-of-frame flags, and each has its own mask.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset the FIFO is empty, and data_ready, dma_req, eof_flag, overflow, irq_ready and irq_eof are all 0.
- R2: Entries leave in the order they were written. rd_byte always shows the byte at the head, and the storage holds DEPTH (default 32) entries.
- R3: thr_sel selects the fill threshold: 0 gives 1 entry, 1 gives DEPTH/4 (8), 2 gives DEPTH/2 (16) and 3 gives DEPTH (32). In the cycle after a write brings the fill level to the threshold or above, dma_req and data_ready are 1 while the head is a data byte.
- R4: After the threshold has been reached, data_ready and dma_req stay at 1 while reads bring the level below the threshold. They drop only when the FIFO is empty.
- R5: While a status entry (wr_is_status=1) is stored, the data bytes ahead of it are readable (data_ready=1) even if the threshold was never reached. dma_req stays 0 in that case.
- R6: When a status entry is at the head, eof_flag=1, data_ready=0, dma_req=0 and rd_byte shows the status byte. A rd_pop in this state has no effect.
- R7: An eof_ack pulse while eof_flag=1 removes the status entry, and only then do the next frame's bytes become readable. An eof_ack while eof_flag=0 has no effect.
- R8: A write to a full FIFO is dropped and sets overflow. Overflow then stays at 1 until reset.
- R9: irq_ready equals data_ready when mask_ready=0 and is 0 when mask_ready=1. irq_eof relates to eof_flag and mask_eof in the same way.
- R10: A rd_pop while data_ready=0 removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write one entry this cycle |
| wr_byte | input | 8 | Byte to write |
| wr_is_status | input | 1 | Written byte is a frame status entry |
| thr_sel | input | 2 | Threshold select (1, DEPTH/4, DEPTH/2, DEPTH) |
| rd_pop | input | 1 | Remove the head data byte |
| eof_ack | input | 1 | Acknowledge and remove the head status entry |
| mask_ready | input | 1 | 1 masks the data-ready interrupt |
| mask_eof | input | 1 | 1 masks the end-of-frame interrupt |
| rd_byte | output | 8 | Byte at the head of the FIFO |
| data_ready | output | 1 | A data byte may be read |
| dma_req | output | 1 | Threshold reached and head is data |
| eof_flag | output | 1 | Status entry at the head |
| overflow | output | 1 | Sticky dropped-write flag |
| irq_ready | output | 1 | Masked data-ready interrupt |
| irq_eof | output | 1 | Masked end-of-frame interrupt |

## Verification
The bench sweeps every threshold from one entry up to a full FIFO and, for each, checks data_ready and dma_req after every single write and every single read. A broken level counter or threshold decode therefore shows up on the first write that crosses the threshold. A pointer that has gone wrong corrupts rd_byte on the very next read, because every read value is compared against the bench's own model of the order. A lost or extra frame-status tag becomes visible at the frame boundary: eof_flag appears early or late, data_ready takes the wrong value, or a read gets through a status entry that has not been acknowledged. An overflow that was not dropped shows up as a 33rd byte, or as a FIFO that does not empty after 32 reads.

// File: rtl/rxf_pkg.sv
// Package: shared types for the frame receive FIFO.
// Assumes byte-wide data; one tag bit marks frame-status entries.
package rxf_pkg;
    localparam int RXF_W = 8;

    typedef struct packed {
        logic             is_stat;
        logic [RXF_W-1:0] val;
    } entry_t;

    typedef enum logic [1:0] {
        THR_ONE     = 2'd0,
        THR_QUARTER = 2'd1,
        THR_HALF    = 2'd2,
        THR_FULL    = 2'd3
    } thr_e;
endpackage

// File: rtl/rxf_store.sv
// Module: circular entry store with level counter and sticky overflow.
// Assumes pop_ok is only raised when the store is non-empty; a write
// arriving while full is discarded.
module rxf_store #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_valid,
    input  rxf_pkg::entry_t            push_entry,
    input  logic                       pop_ok,
    output logic                       push_ok,
    output rxf_pkg::entry_t            head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [$clog2(DEPTH+1)-1:0] count_nxt,
    output logic                       overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    rxf_pkg::entry_t mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;

    // Accept a write only when space is left.
    assign push_ok   = push_valid && (count != CW'(DEPTH));
    assign count_nxt = count + CW'(push_ok) - CW'(pop_ok);
    assign head      = mem[rd_ptr];

    // Entry array write port.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_entry;
    end

    // Pointer, level and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count_nxt;
            if (push_valid && !push_ok) overflow <= 1'b1;
        end
    end

    assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |-> (count != '0));
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push_valid && !pop_ok) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/rxf_ctrl.sv
// Module: read-side flag logic: threshold decode, hysteretic arm bit,
// count of stored status entries, and the ready/DMA/EOF flags.
// Assumes count/count_nxt come from the store, which applies the same
// push/pop decisions.
module rxf_ctrl #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 thr_sel,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [$clog2(DEPTH+1)-1:0] count_nxt,
    input  logic                       head_is_stat,
    input  logic                       push_stat_ok,
    input  logic                       pop_ok,
    output logic                       data_ready,
    output logic                       dma_req,
    output logic                       eof_flag
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0] thr;
    logic [CW-1:0] pend;
    logic          armed;
    logic          empty;

    // Threshold decode from the select field.
    always_comb begin
        case (rxf_pkg::thr_e'(thr_sel))
            rxf_pkg::THR_ONE:     thr = CW'(1);
            rxf_pkg::THR_QUARTER: thr = CW'(DEPTH/4);
            rxf_pkg::THR_HALF:    thr = CW'(DEPTH/2);
            default:              thr = CW'(DEPTH);
        endcase
    end

    // Arm on reaching threshold, disarm only when drained empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed <= 1'b0;
        else if (count_nxt == '0)  armed <= 1'b0;
        else if (count_nxt >= thr) armed <= 1'b1;
    end

    // Number of frame-status entries held in the store.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend + CW'(push_stat_ok) - CW'(pop_ok && head_is_stat);
    end

    // Flags derived from head contents and frame/threshold state.
    assign empty      = (count == '0);
    assign eof_flag   = !empty && head_is_stat;
    assign data_ready = !empty && !head_is_stat && (armed || pend != '0);
    assign dma_req    = !empty && !head_is_stat && armed;

    assert_pend_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= count);
    assert_dma_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> data_ready);
endmodule

// File: rtl/hdlc_rx_fifo.sv
// Module: frame receive FIFO top. Writes carry a status tag; reads are
// gated by the ready/EOF flags; the status entry is removed by eof_ack.
// Assumes a single clock and a synchronous active-low reset.
module hdlc_rx_fifo #(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_byte,
    input  logic       wr_is_status,
    input  logic [1:0] thr_sel,
    input  logic       rd_pop,
    input  logic       eof_ack,
    input  logic       mask_ready,
    input  logic       mask_eof,
    output logic [7:0] rd_byte,
    output logic       data_ready,
    output logic       dma_req,
    output logic       eof_flag,
    output logic       overflow,
    output logic       irq_ready,
    output logic       irq_eof
);
    localparam int CW = $clog2(DEPTH+1);

    rxf_pkg::entry_t wr_entry, head;
    logic [CW-1:0]   count, count_nxt;
    logic            push_ok, pop_ok;

    // Pack write-side inputs into an entry.
    assign wr_entry = '{is_stat: wr_is_status, val: wr_byte};
    // A data read needs data_ready; the status entry needs eof_ack.
    assign pop_ok   = (rd_pop && data_ready) || (eof_ack && eof_flag);
    assign rd_byte  = head.val;
    // Interrupt outputs with active-high masks.
    assign irq_ready = data_ready && !mask_ready;
    assign irq_eof   = eof_flag && !mask_eof;

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (wr_valid),
        .push_entry (wr_entry),
        .pop_ok     (pop_ok),
        .push_ok    (push_ok),
        .head       (head),
        .count      (count),
        .count_nxt  (count_nxt),
        .overflow   (overflow)
    );

    rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .thr_sel      (thr_sel),
        .count        (count),
        .count_nxt    (count_nxt),
        .head_is_stat (head.is_stat),
        .push_stat_ok (push_ok && wr_is_status),
        .pop_ok       (pop_ok),
        .data_ready   (data_ready),
        .dma_req      (dma_req),
        .eof_flag     (eof_flag)
    );

    assert_eof_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_flag && !eof_ack) |=> (eof_flag && $stable(rd_byte)));
    assert_ready_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !rd_pop) |=> data_ready);
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/sim_hdlc_rx_fifo.sv
module sim_hdlc_rx_fifo;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 32;

    logic       clk = 1'b0;
    logic       rst_n, wr_valid, wr_is_status, rd_pop, eof_ack, mask_ready, mask_eof;
    logic [7:0] wr_byte;
    logic [1:0] thr_sel;
    logic [7:0] rd_byte;
    logic       data_ready, dma_req, eof_flag, overflow, irq_ready, irq_eof;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    hdlc_rx_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .wr_is_status(wr_is_status), .thr_sel(thr_sel), .rd_pop(rd_pop),
        .eof_ack(eof_ack), .mask_ready(mask_ready), .mask_eof(mask_eof),
        .rd_byte(rd_byte), .data_ready(data_ready), .dma_req(dma_req),
        .eof_flag(eof_flag), .overflow(overflow), .irq_ready(irq_ready),
        .irq_eof(irq_eof)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 1'b0; wr_valid = 0; wr_is_status = 0; wr_byte = 0;
        rd_pop = 0; eof_ack = 0; mask_ready = 0; mask_eof = 0; thr_sel = sel;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic put(input logic [7:0] b, input logic st);
        wr_valid = 1; wr_byte = b; wr_is_status = st;
        tick();
        wr_valid = 0; wr_is_status = 0;
    endtask

    task automatic pop1();
        rd_pop = 1; tick(); rd_pop = 0;
    endtask

    task automatic ack1();
        eof_ack = 1; tick(); eof_ack = 0;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset(2'd0);
        // R1 reset state
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 eof_flag", int'(eof_flag), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 irq_ready", int'(irq_ready), 0);
        chk("R1 irq_eof", int'(irq_eof), 0);

        // R3 / R4 / R2: sweep every threshold over a full fill and drain
        for (int s = 0; s < 4; s++) begin
            int thr;
            thr = (s == 0) ? 1 : (DEPTH >> (3 - s));
            do_reset(2'(s));
            for (int n = 1; n <= DEPTH; n++) begin
                put(8'((n * 7 + s * 3) & 255), 1'b0);
                chk("R3 data_ready vs level", int'(data_ready), int'(n >= thr));
                chk("R3 dma_req vs level", int'(dma_req), int'(n >= thr));
            end
            for (int n = 1; n <= DEPTH; n++) begin
                chk("R2 order", int'(rd_byte), (n * 7 + s * 3) & 255);
                chk("R4 ready held", int'(data_ready), 1);
                chk("R4 dma held", int'(dma_req), 1);
                pop1();
            end
            chk("R4 drop at empty", int'(data_ready), 0);
            chk("R4 dma drop at empty", int'(dma_req), 0);
        end

        // R5 / R6 / R10: flush below threshold, then status at head
        do_reset(2'd3);
        put(8'hA0, 0); put(8'hA1, 0);
        chk("R5 below threshold no ready", int'(data_ready), 0);
        pop1();
        chk("R10 pop ignored", int'(rd_byte), 8'hA0);
        put(8'hA2, 0); put(8'h5E, 1);
        chk("R5 flush ready", int'(data_ready), 1);
        chk("R5 flush no dma", int'(dma_req), 0);
        for (int i = 0; i < 3; i++) begin
            chk("R5 flush byte", int'(rd_byte), 8'hA0 + i);
            pop1();
        end
        chk("R6 eof_flag", int'(eof_flag), 1);
        chk("R6 ready off", int'(data_ready), 0);
        chk("R6 dma off", int'(dma_req), 0);
        chk("R6 status byte", int'(rd_byte), 8'h5E);
        pop1();
        chk("R6 pop ignored eof", int'(eof_flag), 1);
        chk("R6 pop ignored byte", int'(rd_byte), 8'h5E);
        ack1();
        chk("R7 ack empties", int'(eof_flag), 0);
        chk("R7 ack empties ready", int'(data_ready), 0);

        // R7: next frame blocked until ack; ack without eof ignored
        do_reset(2'd0);
        put(8'h11, 0); put(8'h77, 1); put(8'h22, 0);
        pop1();
        chk("R7 blocked eof", int'(eof_flag), 1);
        chk("R7 blocked ready", int'(data_ready), 0);
        ack1();
        chk("R7 after ack ready", int'(data_ready), 1);
        chk("R7 after ack byte", int'(rd_byte), 8'h22);
        ack1();
        chk("R7 stray ack byte", int'(rd_byte), 8'h22);
        chk("R7 stray ack ready", int'(data_ready), 1);

        // R9: interrupt masking in ready and eof states
        for (int m = 0; m < 2; m++) begin
            mask_ready = 1'(m); mask_eof = 1'(1 - m);
            #1;
            chk("R9 irq_ready", int'(irq_ready), 1 - m);
            chk("R9 irq_eof idle", int'(irq_eof), 0);
        end
        pop1(); put(8'h99, 1);
        for (int m = 0; m < 2; m++) begin
            mask_eof = 1'(m); mask_ready = 1'(1 - m);
            #1;
            chk("R9 irq_eof", int'(irq_eof), 1 - m);
            chk("R9 irq_ready eof", int'(irq_ready), 0);
        end

        // R8: overflow drop and stickiness
        do_reset(2'd3);
        for (int n = 0; n < DEPTH; n++) put(8'(n + 64), 0);
        chk("R8 no overflow yet", int'(overflow), 0);
        put(8'hEE, 0);
        chk("R8 overflow set", int'(overflow), 1);
        for (int n = 0; n < DEPTH; n++) begin
            chk("R8 kept bytes", int'(rd_byte), n + 64);
            pop1();
        end
        chk("R8 dropped byte absent", int'(data_ready), 0);
        chk("R8 overflow sticky", int'(overflow), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule